// File: doc/BRIEF.md
# Dual-Entry Colour Palette RAM

This block holds the colour look-up table of a display pipeline. The table has 256 entries of 16 bits each. The register bus sees it as 128 consecutive 32-bit words, and each word carries two neighbouring entries. Software fills the table through bus writes and can read back exactly the word it stored.

A second port serves the pixel path. It takes an 8-bit pixel index with a valid flag and returns three 8-bit colour channels one cycle later, together with a matching valid flag.

- Each stored entry holds three 5-bit channels and one intensity bit.
- The intensity bit is kept in storage but plays no part in the colour.
- Each 5-bit channel is widened to 8 bits by appending three zero bits.
- Which physical colour each channel drives is decided downstream, so the outputs are named by position: first channel, green, third channel.

The bus port and the pixel port use separate read paths into the storage. A bus write and a pixel lookup in the same cycle therefore never delay each other. When a lookup targets the entry that is being written in that same cycle, the new value is used.

The palette window must start on a byte address that is a multiple of its own size (512 bytes for the default).

Top module: `pal_lut`

## Requirements
- R1: A bus write whose byte address falls in the palette window (BASE_ADDR to BASE_ADDR+0x1FF by default 0x200..0x3FF) stores the full 32-bit data in word (addr-BASE_ADDR)>>2. A bus read of that address returns the stored word unchanged on `bus_rdata` in the cycle after the address is presented.
- R2: A bus write outside the window changes no palette word. A bus read outside the window returns zero on `bus_rdata` one cycle later.
- R3: Palette word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Index bit 0 selects the half.
- R4: Within an entry, bits [4:0] drive `px_c0`, bits [9:5] drive `px_c1` (green), and bits [14:10] drive `px_c2`.
- R5: Entry bit 15 (the intensity bit) is stored and read back on the bus but never changes the looked-up colour.
- R6: Each 5-bit channel appears on its 8-bit output as {channel, 3'b000}.
- R7: `px_vld` is high exactly in the cycle after `pix_vld` was sampled high, and the colour for that index is valid in that same cycle. When `pix_vld` is low, `px_vld` is low in the next cycle and the colour outputs hold their previous values.
- R8: A lookup sampled in the same cycle as an in-window bus write to the word that holds the looked-up entry returns the colour of the newly written data.
- R9: After reset, `bus_rdata` is zero, `px_vld` is low, the colour outputs are zero, and every palette word reads as zero.
- R10: A bus read sampled in the same cycle as an in-window write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address for bus reads and writes |
| bus_wdata | input | 32 | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_rdata | output | 32 | Registered bus read data |
| pix_idx | input | PIX_IDX_W (8) | Palette index from the pixel path |
| pix_vld | input | 1 | Pixel index valid |
| px_c0 | output | 8 | Expanded first channel |
| px_c1 | output | 8 | Expanded green channel |
| px_c2 | output | 8 | Expanded third channel |
| px_vld | output | 1 | Colour outputs valid |

## Verification
Both results of the block are due exactly one clock edge after their stimulus:
- `bus_rdata` follows the edge that samples `bus_addr`.
- the colour and `px_vld` follow the edge that samples `pix_idx` and `pix_vld`.

The bench drives every stimulus shortly after an edge and samples the outputs shortly after the following edge. This holds for the same-cycle write/lookup and write/read collisions as well, where the new data must already be visible at that single edge. The checker relates `px_vld` and the bypassed colour to inputs exactly one cycle back. It also checks that the colour outputs stay unchanged in any cycle that follows an idle input cycle.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int CH_IN_W  = 5;
  localparam int CH_OUT_W = 8;
  localparam int ENTRY_W  = 16;
  localparam int WORD_W   = 2 * ENTRY_W;

  typedef struct packed {
    logic [CH_OUT_W-1:0] c2;
    logic [CH_OUT_W-1:0] c1;
    logic [CH_OUT_W-1:0] c0;
  } colour_t;

  function automatic logic [CH_OUT_W-1:0] widen(input logic [CH_IN_W-1:0] ch);
    return {ch, {(CH_OUT_W-CH_IN_W){1'b0}}};
  endfunction

  function automatic colour_t entry_to_colour(input logic [ENTRY_W-1:0] e);
    colour_t c;
    c.c0 = widen(e[CH_IN_W-1:0]);
    c.c1 = widen(e[2*CH_IN_W-1:CH_IN_W]);
    c.c2 = widen(e[3*CH_IN_W-1:2*CH_IN_W]);
    return c;
  endfunction
endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS  = 128,
  parameter int WIDX_W = $clog2(WORDS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [WIDX_W-1:0]                wr_idx,
  input  logic [pal_lut_pkg::WORD_W-1:0]   wr_data,
  input  logic [WIDX_W-1:0]                rd_idx_a,
  output logic [pal_lut_pkg::WORD_W-1:0]   rd_data_a,
  input  logic [WIDX_W-1:0]                rd_idx_b,
  output logic [pal_lut_pkg::WORD_W-1:0]   rd_data_b
);
  logic [pal_lut_pkg::WORD_W-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic word_ce;
    assign word_ce = wr_en && (wr_idx == WIDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[w] <= '0;
      else if (word_ce) word_q[w] <= wr_data;
    end
  end

  always_comb begin
    rd_data_a = word_q[rd_idx_a];
    rd_data_b = word_q[rd_idx_b];
  end
endmodule

// File: rtl/pal_bus_port.sv
module pal_bus_port #(
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int WORDS     = 128,
  parameter int WIDX_W    = $clog2(WORDS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [pal_lut_pkg::WORD_W-1:0] bus_wdata,
  input  logic                           bus_we,
  output logic [pal_lut_pkg::WORD_W-1:0] bus_rdata,
  output logic                           wr_hit,
  output logic [WIDX_W-1:0]              word_idx,
  input  logic [pal_lut_pkg::WORD_W-1:0] store_word
);
  localparam int SPAN_W = WIDX_W + 2;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic                           in_win;
  logic [pal_lut_pkg::WORD_W-1:0] rdata_nxt;

  always_comb begin
    in_win   = (bus_addr[ADDR_W-1:SPAN_W] == BASE_V[ADDR_W-1:SPAN_W]);
    word_idx = bus_addr[SPAN_W-1:2];
    wr_hit   = bus_we && in_win;
    if (!in_win)     rdata_nxt = '0;
    else if (bus_we) rdata_nxt = bus_wdata;
    else             rdata_nxt = store_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_nxt;
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int ENTRIES   = 256,
  parameter int PIX_IDX_W = $clog2(ENTRIES),
  parameter int WIDX_W    = PIX_IDX_W - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PIX_IDX_W-1:0]           pix_idx,
  input  logic                           pix_vld,
  output logic [WIDX_W-1:0]              look_widx,
  input  logic [pal_lut_pkg::WORD_W-1:0] store_word,
  input  logic                           wr_hit,
  input  logic [WIDX_W-1:0]              wr_idx,
  input  logic [pal_lut_pkg::WORD_W-1:0] wr_data,
  output pal_lut_pkg::colour_t           colour,
  output logic                           colour_vld
);
  import pal_lut_pkg::*;

  logic [WORD_W-1:0]  word_sel;
  logic [ENTRY_W-1:0] entry_sel;
  colour_t            colour_nxt;

  always_comb begin
    look_widx  = pix_idx[PIX_IDX_W-1:1];
    word_sel   = (wr_hit && (wr_idx == look_widx)) ? wr_data : store_word;
    entry_sel  = pix_idx[0] ? word_sel[WORD_W-1:ENTRY_W] : word_sel[ENTRY_W-1:0];
    colour_nxt = entry_to_colour(entry_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) colour_vld <= 1'b0;
    else        colour_vld <= pix_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       colour <= '0;
    else if (pix_vld) colour <= colour_nxt;
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int ENTRIES   = 256,
  parameter int PIX_IDX_W = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  output logic [31:0]          bus_rdata,
  input  logic [PIX_IDX_W-1:0] pix_idx,
  input  logic                 pix_vld,
  output logic [7:0]           px_c0,
  output logic [7:0]           px_c1,
  output logic [7:0]           px_c2,
  output logic                 px_vld
);
  localparam int WORDS  = ENTRIES / 2;
  localparam int WIDX_W = $clog2(WORDS);

  logic                 wr_hit;
  logic [WIDX_W-1:0]    bus_widx;
  logic [WIDX_W-1:0]    look_widx;
  logic [31:0]          bus_word;
  logic [31:0]          look_word;
  pal_lut_pkg::colour_t colour;

  pal_store #(.WORDS(WORDS), .WIDX_W(WIDX_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_hit), .wr_idx(bus_widx), .wr_data(bus_wdata),
    .rd_idx_a(bus_widx), .rd_data_a(bus_word),
    .rd_idx_b(look_widx), .rd_data_b(look_word)
  );

  pal_bus_port #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WORDS(WORDS),
                 .WIDX_W(WIDX_W)) bus_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .wr_hit(wr_hit), .word_idx(bus_widx),
    .store_word(bus_word)
  );

  pal_lookup #(.ENTRIES(ENTRIES), .PIX_IDX_W(PIX_IDX_W), .WIDX_W(WIDX_W)) look_i (
    .clk(clk), .rst_n(rst_n),
    .pix_idx(pix_idx), .pix_vld(pix_vld), .look_widx(look_widx),
    .store_word(look_word), .wr_hit(wr_hit), .wr_idx(bus_widx),
    .wr_data(bus_wdata), .colour(colour), .colour_vld(px_vld)
  );

  assign px_c0 = colour.c0;
  assign px_c1 = colour.c1;
  assign px_c2 = colour.c2;
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int ENTRIES   = 256,
  parameter int PIX_IDX_W = $clog2(ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_we,
  input logic [31:0]          bus_rdata,
  input logic [PIX_IDX_W-1:0] pix_idx,
  input logic                 pix_vld,
  input logic [7:0]           px_c0,
  input logic [7:0]           px_c1,
  input logic [7:0]           px_c2,
  input logic                 px_vld
);
  localparam int WIN_BYTES = ENTRIES * 2;

  logic        in_win;
  logic [31:0] woff;
  logic        same_word;
  logic [15:0] new_entry;

  always_comb begin
    in_win    = (32'(bus_addr) >= 32'(BASE_ADDR)) &&
                (32'(bus_addr) <  32'(BASE_ADDR + WIN_BYTES));
    woff      = (32'(bus_addr) - 32'(BASE_ADDR)) >> 2;
    same_word = in_win && bus_we && pix_vld && (32'(pix_idx >> 1) == woff);
    new_entry = pix_idx[0] ? bus_wdata[31:16] : bus_wdata[15:0];
  end

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> px_vld);
  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> !px_vld);
  // R7
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ($stable(px_c0) && $stable(px_c1) && $stable(px_c2)));
  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |-> (px_c0[2:0] == 3'b0 && px_c1[2:0] == 3'b0 && px_c2[2:0] == 3'b0));
  // R2
  out_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> (bus_rdata == 32'h0));
  // R10
  write_read_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_win) |=> (bus_rdata == $past(bus_wdata)));
  // R8
  lookup_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_word |=> (px_c0[7:3] == $past(new_entry[4:0]) &&
                   px_c1[7:3] == $past(new_entry[9:5]) &&
                   px_c2[7:3] == $past(new_entry[14:10])));
endmodule

bind pal_lut pal_lut_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ENTRIES(ENTRIES), .PIX_IDX_W(PIX_IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_vld(pix_vld),
  .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2), .px_vld(px_vld)
);

// File: tb/pal_lut_tb_top.sv
module pal_lut_tb_top;
  localparam int ADDR_W  = 12;
  localparam int BASE    = 'h200;
  localparam int ENTRIES = 256;
  localparam int WORDS   = ENTRIES / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_we;
  logic [31:0]       bus_rdata;
  logic [7:0]        pix_idx;
  logic              pix_vld;
  logic [7:0]        px_c0, px_c1, px_c2;
  logic              px_vld;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [WORDS];

  always #4 clk = ~clk;

  pal_lut #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pix_idx(pix_idx), .pix_vld(pix_vld),
    .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2), .px_vld(px_vld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_colour(input logic [7:0] idx);
    logic [15:0] e;
    e = idx[0] ? model[idx >> 1][31:16] : model[idx >> 1][15:0];
    return {e[14:10], 3'b0, e[9:5], 3'b0, e[4:0], 3'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] waddr(input int n);
    return ADDR_W'(BASE + n * 4);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    step();
    d = bus_rdata;
  endtask

  task automatic lookup(input logic [7:0] idx, input string req);
    pix_idx = idx; pix_vld = 1'b1;
    step();
    pix_vld = 1'b0;
    check(px_vld === 1'b1, {req, " valid"}, 32'(px_vld), 32'h1);
    check({px_c2, px_c1, px_c0} === exp_colour(idx), req,
          32'({px_c2, px_c1, px_c0}), 32'(exp_colour(idx)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R7 actual=%h expected=%h", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] held;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    pix_idx = '0; pix_vld = 1'b0;
    for (int n = 0; n < WORDS; n++) model[n] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R9 reset state
    check(bus_rdata === 32'h0, "R9 rdata", bus_rdata, 32'h0);
    check(px_vld === 1'b0, "R9 px_vld", 32'(px_vld), 32'h0);
    check({px_c2, px_c1, px_c0} === 24'h0, "R9 colour", 32'({px_c2, px_c1, px_c0}), 32'h0);
    bus_read(waddr(77), rd);
    check(rd === 32'h0, "R9 word reads zero", rd, 32'h0);

    // R1 fill all words, read each back
    for (int n = 0; n < WORDS; n++) begin
      model[n] = (32'(n) * 32'h9E3779B1) ^ (32'(n) << 11);
      bus_write(waddr(n), model[n]);
    end
    for (int n = 0; n < WORDS; n++) begin
      bus_read(waddr(n), rd);
      check(rd === model[n], "R1 read back", rd, model[n]);
    end

    // R3 R4 R6 exhaustive lookup
    for (int i = 0; i < ENTRIES; i++) lookup(8'(i), "R3 R4 R6 lookup");

    // R5 intensity bit ignored for colour but stored
    model[9] = 32'h0000_5A6B;
    bus_write(waddr(9), model[9]);
    lookup(8'd18, "R5 intensity clear");
    held = {px_c2, px_c1, px_c0};
    model[9] = 32'h0000_DA6B;
    bus_write(waddr(9), model[9]);
    lookup(8'd18, "R5 intensity set");
    check({px_c2, px_c1, px_c0} === held, "R5 same colour", 32'({px_c2, px_c1, px_c0}), 32'(held));
    bus_read(waddr(9), rd);
    check(rd === 32'h0000_DA6B, "R5 bit stored", rd, 32'h0000_DA6B);

    // R2 out-of-window writes and reads
    bus_write(12'h1FC, 32'hDEAD_BEEF);
    bus_write(12'h400, 32'hCAFE_F00D);
    bus_write(12'h000, 32'h1234_5678);
    bus_read(12'h1FC, rd);
    check(rd === 32'h0, "R2 read below window", rd, 32'h0);
    bus_read(12'h400, rd);
    check(rd === 32'h0, "R2 read above window", rd, 32'h0);
    for (int n = 0; n < WORDS; n++) begin
      bus_read(waddr(n), rd);
      check(rd === model[n], "R2 palette untouched", rd, model[n]);
    end
    lookup(8'd0, "R2 lookup untouched");
    lookup(8'd255, "R2 lookup untouched");

    // R8 R10 same-cycle write and lookup to same word
    model[5] = 32'h7C1F_03E0;
    bus_addr = waddr(5); bus_wdata = model[5]; bus_we = 1'b1;
    pix_idx = 8'd11; pix_vld = 1'b1;
    step();
    bus_we = 1'b0; pix_vld = 1'b0;
    check({px_c2, px_c1, px_c0} === exp_colour(8'd11), "R8 bypass upper",
          32'({px_c2, px_c1, px_c0}), 32'(exp_colour(8'd11)));
    check(bus_rdata === model[5], "R10 read bypass", bus_rdata, model[5]);
    model[6] = 32'h0421_7FFF;
    bus_addr = waddr(6); bus_wdata = model[6]; bus_we = 1'b1;
    pix_idx = 8'd12; pix_vld = 1'b1;
    step();
    bus_we = 1'b0; pix_vld = 1'b0;
    check({px_c2, px_c1, px_c0} === exp_colour(8'd12), "R8 bypass lower",
          32'({px_c2, px_c1, px_c0}), 32'(exp_colour(8'd12)));

    // R7 idle cycle: valid drops, colour holds
    lookup(8'd40, "R7 lookup");
    held = {px_c2, px_c1, px_c0};
    pix_idx = 8'd41; pix_vld = 1'b0;
    step();
    check(px_vld === 1'b0, "R7 valid low", 32'(px_vld), 32'h0);
    check({px_c2, px_c1, px_c0} === held, "R7 colour held", 32'({px_c2, px_c1, px_c0}), 32'(held));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule